// File: doc/BRIEF.md
# UART Transmitter with Holding Buffer

This block is the transmit half of a UART. Software places one character into a single holding register. The block moves that character into a shift register and sends it on one serial line. Each frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts exactly one period of an external baud tick. Four configuration inputs set the frame shape at run time: the character length (7 or 8 bits), the number of stop bits, whether parity is present, and whether parity is even or odd.

The holding register empties at the moment its contents enter the shift register. That moment raises a one-cycle empty interrupt. Software can then write the next character while the current frame is still on the line. The block sends the queued character directly after the last stop bit of the current frame, with no idle gap. A busy flag stays high while any character is waiting or being sent.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset the serial line is high and both `busy` and `emptyIrq` are low. With the configuration inputs held at 0, a frame has 7 data bits, 1 stop bit and no parity.
- R2: A write to the holding register while the line is idle starts a frame at the next baud tick, with no other trigger. The frame opens with one low start bit that lasts exactly one tick period.
- R3: Data bits follow the start bit, least significant bit first. A data bit of 1 drives the line high and a 0 drives it low. Every bit lasts one tick period.
- R4: When `cfgLen8`=1 the frame carries 8 data bits. When it is 0 the frame carries 7 data bits, and bit 7 of the written byte is not sent.
- R5: The frame ends with high stop bits: one when `cfgStop2`=0 and two when it is 1.
- R6: The parity bit follows the data bits only when `cfgParEn`=1. `cfgParEven`=1 makes the count of ones in the active data bits plus parity even, and 0 makes it odd. Bit 7 is left out of the count in 7-bit mode, and `cfgParEven` has no effect when parity is disabled.
- R7: `emptyIrq` pulses high for exactly one clock when the holding register moves into the shift register. That is the clock in which the start bit appears, not the end of the frame.
- R8: A character written while a frame is shifting is sent starting at the baud tick that ends the last stop bit, with no idle bit time between the frames.
- R9: `busy` is high from the clock after a write until the last stop bit of the last queued frame has ended. It is low otherwise.
- R10: The frame shape is captured at the transfer into the shift register. Changes to the configuration inputs after that transfer do not alter the frame on the line.
- R11: The serial line changes level only on a clock in which `baudTick` was high. It stays high when no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-clock pulse marking each bit period boundary |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | DATA_W | Character to send |
| cfgLen8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgStop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfgParEn | input | 1 | 1: append a parity bit |
| cfgParEven | input | 1 | 1: even parity, 0: odd parity |
| txLine | output | 1 | Serial output line, idles high |
| emptyIrq | output | 1 | One-clock pulse when the holding register empties |
| busy | output | 1 | A character is waiting or a frame is in progress |

## Verification
The frame builder is driven with characters that have bit 7 set in 7-bit mode, which separates a sent bit 7 from a dropped one. Parity cases are chosen so the parity bit value differs between even and odd mode, and between counting and not counting bit 7. Separate frames with one and two stop bits reveal a wrong frame length. A chain of characters, each written right after the previous empty interrupt, shows whether a gap appears between frames. A change of configuration right after one of these interrupts shows whether the frame shape is captured at transfer or read live.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Strobes from the control unit to the datapath, valid for one clock.
  typedef struct packed {
    logic holdWrite;  // capture wrData into the holding register
    logic transfer;   // move holding register into the shifter, start a frame
    logic shift;      // advance to the next bit of the current frame
    logic finish;     // last bit done and nothing queued: go idle
  } txCtl_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   baudTick,
  input  logic   wrEn,
  input  logic   holdFull,
  input  logic   active,
  input  logic   lastBit,
  output txCtl_t ctl,
  output logic   emptyIrq
);

  logic frameEnds;

  always_comb begin
    frameEnds        = baudTick & active & lastBit;
    ctl.holdWrite    = wrEn;
    // A queued character starts on an idle tick or on the tick that closes
    // the last stop bit, so consecutive frames abut.
    ctl.transfer     = baudTick & holdFull & (~active | lastBit);
    ctl.shift        = baudTick & active & ~lastBit;
    ctl.finish       = frameEnds & ~holdFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) emptyIrq <= 1'b0;
    else       emptyIrq <= ctl.transfer;
  end

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgLen8,
  input  logic              cfgStop2,
  input  logic              cfgParEn,
  input  logic              cfgParEven,
  output logic              holdFull,
  output logic              active,
  output logic              lastBit,
  output logic              txLine
);

  // start + data + parity + two stops
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  holdReg;
  logic [DATA_W-1:0]  dataMask;
  logic [DATA_W-1:0]  maskedData;
  logic               parityBit;
  logic [CNT_W-1:0]   parPos;
  logic [FRAME_W-1:0] nextFrame;
  logic [CNT_W-1:0]   nextLast;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]   lastIdx;

  // Holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (ctl.holdWrite) begin
      holdReg  <= wrData;
      holdFull <= 1'b1;
    end else if (ctl.transfer) begin
      holdFull <= 1'b0;
    end
  end

  // Frame assembly from the holding register and the live configuration
  always_comb begin
    dataMask = '1;
    if (!cfgLen8) dataMask[DATA_W-1] = 1'b0;
    maskedData = holdReg & dataMask;
    parityBit  = (^maskedData) ^ ~cfgParEven;
    parPos     = cfgLen8 ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);

    nextFrame    = '1;
    nextFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) nextFrame[1+i] = maskedData[i];
    if (!cfgLen8) nextFrame[DATA_W] = 1'b1;
    if (cfgParEn) nextFrame[parPos] = parityBit;

    nextLast = CNT_W'(DATA_W - 1) + CNT_W'(cfgLen8) + CNT_W'(cfgParEn)
             + CNT_W'(cfgStop2) + CNT_W'(1);
  end

  // Shift register and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitCnt   <= '0;
      lastIdx  <= '0;
      active   <= 1'b0;
    end else if (ctl.transfer) begin
      shiftReg <= nextFrame;
      bitCnt   <= '0;
      lastIdx  <= nextLast;
      active   <= 1'b1;
    end else if (ctl.shift) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      bitCnt   <= bitCnt + CNT_W'(1);
    end else if (ctl.finish) begin
      shiftReg <= '1;
      active   <= 1'b0;
    end
  end

  assign lastBit = (bitCnt == lastIdx);
  assign txLine  = active ? shiftReg[0] : 1'b1;

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgLen8,
  input  logic              cfgStop2,
  input  logic              cfgParEn,
  input  logic              cfgParEven,
  output logic              txLine,
  output logic              emptyIrq,
  output logic              busy
);

  txCtl_t ctl;
  logic   holdFull;
  logic   active;
  logic   lastBit;

  uart_tx_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .wrEn     (wrEn),
    .holdFull (holdFull),
    .active   (active),
    .lastBit  (lastBit),
    .ctl      (ctl),
    .emptyIrq (emptyIrq)
  );

  uart_tx_datapath #(.DATA_W(DATA_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wrData     (wrData),
    .cfgLen8    (cfgLen8),
    .cfgStop2   (cfgStop2),
    .cfgParEn   (cfgParEn),
    .cfgParEven (cfgParEven),
    .holdFull   (holdFull),
    .active     (active),
    .lastBit    (lastBit),
    .txLine     (txLine)
  );

  assign busy = holdFull | active;

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic wrEn,
  input logic txLine,
  input logic emptyIrq,
  input logic busy
);

  // R7: the empty interrupt never lasts longer than one clock
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    emptyIrq |=> !emptyIrq);

  // R7: the empty interrupt follows a baud tick
  a_r7_irq_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    emptyIrq |-> $past(baudTick));

  // R2: the interrupt coincides with the start bit on the line
  a_r2_irq_with_start: assert property (@(posedge clk) disable iff (!rstN)
    emptyIrq |-> !txLine);

  // R11: idle line is high
  a_r11_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R11: the line moves only after a baud tick
  a_r11_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> $past(baudTick));

  // R9: a write makes the block busy in the next clock
  a_r9_write_busy: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> busy);

endmodule

bind uart_tx_hold uart_tx_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .baudTick (baudTick),
  .wrEn     (wrEn),
  .txLine   (txLine),
  .emptyIrq (emptyIrq),
  .busy     (busy)
);

// File: tb/tb_uart_tx_hold.sv
module tb_uart_tx_hold;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] tickCnt = '0;
  logic baudTick;
  logic wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic cfgLen8 = 1'b0, cfgStop2 = 1'b0, cfgParEn = 1'b0, cfgParEven = 1'b0;
  logic txLine, emptyIrq, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  // one baud tick every 8 clocks
  always @(posedge clk) tickCnt <= tickCnt + 3'd1;
  assign baudTick = (tickCnt == 3'd7);

  uart_tx_hold #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrEn(wrEn), .wrData(wrData),
    .cfgLen8(cfgLen8), .cfgStop2(cfgStop2), .cfgParEn(cfgParEn),
    .cfgParEven(cfgParEven), .txLine(txLine), .emptyIrq(emptyIrq), .busy(busy)
  );

  typedef struct {
    logic [11:0] bits;
    int          n;
    int          len;
    bit          par;
    bit          b2b;
  } frame_t;

  frame_t expQ[$];
  int checks = 0, fails = 0, writes = 0, irqCount = 0;

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: build the expected frame from the requirements and push it
  task automatic sendByte(input logic [7:0] d, input bit b2b);
    frame_t f;
    int len = cfgLen8 ? 8 : 7;
    logic ones = 1'b0;
    int pos;
    f.bits = '1;
    f.bits[0] = 1'b0;                                   // R2 start bit
    for (int i = 0; i < len; i++) begin
      f.bits[1+i] = d[i];                                // R3 LSB first, R4 length
      ones ^= d[i];
    end
    pos = 1 + len;
    if (cfgParEn) begin
      f.bits[pos] = cfgParEven ? ones : ~ones;            // R6
      pos++;
    end
    f.n   = pos + (cfgStop2 ? 2 : 1);                     // R5
    f.len = len;
    f.par = cfgParEn;
    f.b2b = b2b;
    expQ.push_back(f);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    writes++;
    chk(busy == 1'b1, "R9 busy after write", busy, 1'b1);
  endtask

  task automatic waitIrq();
    do @(negedge clk); while (!emptyIrq);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    repeat (16) @(negedge clk);
    chk(txLine == 1'b1, "R11 idle line", txLine, 1'b1);
    chk(busy == 1'b0, "R9 busy idle", busy, 1'b0);
  endtask

  // Monitor: sample the middle of each bit period and compare with the queue
  frame_t cur;
  int  rem = 0, idx = 0;
  bit  mustStart = 0;
  logic prevLine = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (emptyIrq) begin
        irqCount++;
        // R7: interrupt at the start bit, after a high line, not at frame end
        chk(txLine == 1'b0 && prevLine == 1'b1, "R7 irq at transfer", txLine, 1'b0);
      end
      if (tickCnt == 3'd4) begin
        if (rem == 0) begin
          if (mustStart) begin
            chk(txLine == 1'b0, "R8 no gap between frames", txLine, 1'b0);
            mustStart = 0;
          end
          if (txLine == 1'b0) begin
            if (expQ.size() == 0) begin
              chk(1'b0, "R2 unexpected frame", txLine, 1'b1);
            end else begin
              cur = expQ.pop_front();
              chk(1'b1, "R2 start bit", txLine, 1'b0);
              idx = 1;
              rem = cur.n - 1;
            end
          end
        end else begin
          if (idx <= cur.len)
            chk(txLine == cur.bits[idx], "R3/R4 data bit", txLine, cur.bits[idx]);
          else if (cur.par && idx == cur.len + 1)
            chk(txLine == cur.bits[idx], "R6 parity bit", txLine, cur.bits[idx]);
          else
            chk(txLine == cur.bits[idx], "R5 stop bit", txLine, cur.bits[idx]);
          idx++;
          rem--;
          if (rem == 0) mustStart = (expQ.size() > 0) && expQ[0].b2b;
        end
      end
      prevLine = txLine;
    end
  end

  task automatic runTests();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txLine == 1'b1, "R1 reset line", txLine, 1'b1);
    chk(busy == 1'b0, "R1 reset busy", busy, 1'b0);
    chk(emptyIrq == 1'b0, "R1 reset irq", emptyIrq, 1'b0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(txLine == 1'b1, "R11 idle after reset", txLine, 1'b1);

    // R1 default shape, R4 bit 7 dropped in 7-bit mode
    sendByte(8'hA5, 0); waitIdle();
    sendByte(8'h80, 0); waitIdle();

    // R4 8-bit, no parity
    cfgLen8 = 1'b1;
    sendByte(8'h3C, 0); waitIdle();
    sendByte(8'h81, 0); waitIdle();

    // R6 even parity, 8 bits
    cfgParEn = 1'b1; cfgParEven = 1'b1;
    sendByte(8'h0F, 0); waitIdle();
    sendByte(8'h07, 0); waitIdle();

    // R6 odd parity, 7 bits, bit 7 excluded from count
    cfgLen8 = 1'b0; cfgParEven = 1'b0;
    sendByte(8'hFF, 0); waitIdle();
    sendByte(8'h7E, 0); waitIdle();

    // R5 two stop bits
    cfgStop2 = 1'b1; cfgParEn = 1'b0;
    sendByte(8'h55, 0); waitIdle();

    // R8 back-to-back writes, R10 config change after each transfer
    cfgLen8 = 1'b1; cfgParEn = 1'b1; cfgParEven = 1'b1; cfgStop2 = 1'b1;
    sendByte(8'hC3, 0);
    waitIrq();
    cfgLen8 = 1'b0; cfgParEven = 1'b0; cfgStop2 = 1'b0;   // R10
    sendByte(8'hF1, 1);
    waitIrq();
    cfgLen8 = 1'b1; cfgParEn = 1'b0; cfgStop2 = 1'b1;     // R10
    sendByte(8'h12, 1);
    waitIrq();
    cfgLen8 = 1'b0; cfgParEn = 1'b1; cfgParEven = 1'b1;   // R10 after last transfer
    waitIdle();

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2 frames not sent: actual %0d expected 0", expQ.size());
    end
    checks++;
    if (irqCount != writes) begin
      fails++;
      $display("FAIL R7 irq count: actual %0d expected %0d", irqCount, writes);
    end
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule